// File: doc/BRIEF.md
# Four-State Snooping Write-Back Cache Controller

This block is a private write-back cache controller for one processor on a shared, atomic bus. It keeps every line coherent with the other controllers on that bus by using four line states and invalidation. The cache is direct-mapped and holds one data word per line. The processor presents one access at a time and holds its request until the controller raises a one-cycle ready pulse.

The controller asks the arbiter for the bus when it needs a transaction. In the grant cycle it drives an address phase carrying a read, a read-for-ownership or a writeback. A fill is installed as Exclusive or Shared according to the wired-OR shared line, which is sampled in the cycle after the address phase. A write to an Exclusive line becomes Modified without bus traffic.

The controller also snoops the address phases of the other controllers. In the cycle after such an address it votes on the shared line when it holds the block. When it owns dirty data it flushes that data and raises a memory-inhibit output, so that main memory does not also answer the request.

Top module: `mesi_cache`

## Requirements
- R1: After reset every line is Invalid, bus_req_o, shared_o, flush_o and cpu_ready_o are low, and the first access to any address misses.
- R2: A read miss whose shared-line sample is low drives one address phase with command code 1 (read), returns the fill word and installs the line Exclusive, so a later write to it drives no address phase.
- R3: A read miss whose shared-line sample is high installs the line Shared, and a later write to that line drives an address phase with command code 2 (read-for-ownership) for the line's address.
- R4: A read hit drives no address phase and returns the stored word; every access ends with cpu_ready_o high for exactly one cycle.
- R5: A write miss drives a read-for-ownership (code 2) and installs the line Modified holding the written word, which a later read hit returns.
- R6: In the cycle after a snooped read (code 1) address, shared_o is high exactly when the line at index snp_addr_i[1:0] is valid with a matching tag.
- R7: A snooped read that hits a Modified line raises flush_o and mem_inhibit_o with the line's word on flush_data_o in the cycle after the address, and the line becomes Shared.
- R8: A snooped read that hits an Exclusive line does not flush, and the line becomes Shared.
- R9: A snooped read-for-ownership (code 2) that hits a Modified line flushes it and invalidates it; one that hits a Shared or Exclusive line invalidates it without a flush.
- R10: A miss whose victim (same index, bits [1:0]) is Modified first drives a writeback (code 3) with the victim's address and word and keeps requesting for the fill; a miss that evicts a Shared or Exclusive line drives only the fill.
- R11: The shared line is sampled only in the cycle right after the controller's own address phase; a vote in any later cycle has no effect on the fill state.
- R12: An address phase is driven only in a cycle where bus_gnt_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address of the access |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant for this cycle |
| bus_av_o | output | 1 | Address phase valid |
| bus_cmd_o | output | 2 | Command: 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr_o | output | ADDR_W | Address of the address phase |
| bus_data_o | output | DATA_W | Writeback data |
| bus_shared_i | input | 1 | Wired-OR shared line |
| bus_dvalid_i | input | 1 | Fill data valid |
| bus_data_i | input | DATA_W | Fill data |
| snp_valid_i | input | 1 | Another controller's address phase |
| snp_cmd_i | input | 2 | Snooped command |
| snp_addr_i | input | ADDR_W | Snooped address |
| shared_o | output | 1 | This controller's vote on the shared line |
| flush_o | output | 1 | Dirty data supplied on the bus |
| flush_data_o | output | DATA_W | Flushed word |
| mem_inhibit_o | output | 1 | Stops memory from answering |

## Verification
The bench targets the transitions that the protocol does not make obvious. It checks that a write to an Exclusive line stays off the bus; a design without the silent upgrade would drive a read-for-ownership. It checks that a write to a Shared line does issue one; a design that treated Shared as writable would leave stale copies in other caches. It checks that snooped reads demote Modified and Exclusive lines to Shared, which is visible through the next local write, and that a read-for-ownership invalidates a line, which is visible through the next local read missing. It also checks that an eviction writes back only dirty victims, with the victim's own address, and that a late vote on the shared line is ignored; a controller that sampled that line in the wrong cycle would install a Shared line where an Exclusive one belongs.

// File: rtl/mesi_pkg.sv
// Shared types of the snooping cache controller: line states and bus commands.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
// Direct-mapped line storage (state, tag, one data word) with two access ports.
// Port A (request side) reads and writes whole lines; port B (snoop side) reads
// lines and rewrites only the state. Assumes the two ports never write the same
// index in the same cycle; if they do, port A wins.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx_i,
    output line_st_t          a_st_o,
    output logic [TAG_W-1:0]  a_tag_o,
    output logic [DATA_W-1:0] a_data_o,
    input  logic              a_we_i,
    input  line_st_t          a_st_i,
    input  logic [TAG_W-1:0]  a_tag_i,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic [IDX_W-1:0]  b_idx_i,
    output line_st_t          b_st_o,
    output logic [TAG_W-1:0]  b_tag_o,
    output logic [DATA_W-1:0] b_data_o,
    input  logic              b_we_i,
    input  line_st_t          b_st_i
);
    localparam int LINES = 1 << IDX_W;

    line_st_t          st_arr   [LINES];
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_t st_r;
        // Per-line state register, reset to Invalid.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_r <= ST_I;
            else if (a_we_i && a_idx_i == IDX_W'(i))
                st_r <= a_st_i;
            else if (b_we_i && b_idx_i == IDX_W'(i))
                st_r <= b_st_i;
        end
        assign st_arr[i] = st_r;
    end

    // Tag and data words: written only by the request port, no reset needed.
    always_ff @(posedge clk) begin
        if (a_we_i) begin
            tag_arr[a_idx_i]  <= a_tag_i;
            data_arr[a_idx_i] <= a_data_i;
        end
    end

    assign a_st_o   = st_arr[a_idx_i];
    assign a_tag_o  = tag_arr[a_idx_i];
    assign a_data_o = data_arr[a_idx_i];
    assign b_st_o   = st_arr[b_idx_i];
    assign b_tag_o  = tag_arr[b_idx_i];
    assign b_data_o = data_arr[b_idx_i];
endmodule

// File: rtl/mesi_snoop.sv
// Snoop side: registers another controller's address phase, then in the next
// cycle looks the line up, votes on the shared line, flushes dirty data and
// demotes or invalidates the line. Assumes an atomic bus: no address phase of
// this controller coincides with the lookup cycle.
module mesi_snoop
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snp_valid_i,
    input  logic [1:0]              snp_cmd_i,
    input  logic [ADDR_W-1:0]       snp_addr_i,
    output logic [IDX_W-1:0]        idx_o,
    input  line_st_t                st_i,
    input  logic [ADDR_W-IDX_W-1:0] tag_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    st_we_o,
    output line_st_t                st_new_o,
    output logic                    vote_o,
    output logic                    flush_o,
    output logic [DATA_W-1:0]       flush_data_o,
    output logic                    busy_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              q_v;
    bus_cmd_t          q_cmd;
    logic [ADDR_W-1:0] q_addr;
    logic              hit;

    // Capture the snooped address phase for a lookup in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v    <= 1'b0;
            q_cmd  <= CMD_NONE;
            q_addr <= '0;
        end else begin
            q_v    <= snp_valid_i;
            q_cmd  <= bus_cmd_t'(snp_cmd_i);
            q_addr <= snp_addr_i;
        end
    end

    assign idx_o        = q_addr[IDX_W-1:0];
    assign hit          = q_v && (st_i != ST_I) && (tag_i == q_addr[ADDR_W-1 -: TAG_W]);
    assign vote_o       = hit && (q_cmd == CMD_RD);
    assign flush_o      = hit && (st_i == ST_M) && (q_cmd == CMD_RD || q_cmd == CMD_RDX);
    assign flush_data_o = data_i;
    assign busy_o       = q_v;

    // Next state of the snooped line: reads demote owners, ownership requests invalidate.
    always_comb begin
        st_we_o  = 1'b0;
        st_new_o = st_i;
        if (hit) begin
            case (q_cmd)
                CMD_RD: if (st_i != ST_S) begin
                    st_we_o  = 1'b1;
                    st_new_o = ST_S;
                end
                CMD_RDX: begin
                    st_we_o  = 1'b1;
                    st_new_o = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_req_fsm.sv
// Request side: serves one processor access at a time. Hits complete locally;
// misses, and writes to Shared lines, win the bus, optionally write back a dirty
// victim, issue a read or read-for-ownership, sample the shared line one cycle
// after their own address phase and install the fill. Assumes the arbiter never
// grants in the cycle that follows another controller's address phase.
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_i,
    input  logic                    cpu_we_i,
    input  logic [ADDR_W-1:0]       cpu_addr_i,
    input  logic [DATA_W-1:0]       cpu_wdata_i,
    output logic                    cpu_ready_o,
    output logic [DATA_W-1:0]       cpu_rdata_o,
    input  logic                    snoop_busy_i,
    output logic [IDX_W-1:0]        idx_o,
    input  line_st_t                st_i,
    input  logic [ADDR_W-IDX_W-1:0] tag_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    we_o,
    output line_st_t                st_new_o,
    output logic [ADDR_W-IDX_W-1:0] tag_new_o,
    output logic [DATA_W-1:0]       data_new_o,
    output logic                    bus_req_o,
    input  logic                    bus_gnt_i,
    output logic                    bus_av_o,
    output logic [1:0]              bus_cmd_o,
    output logic [ADDR_W-1:0]       bus_addr_o,
    output logic [DATA_W-1:0]       bus_data_o,
    input  logic                    bus_shared_i,
    input  logic                    bus_dvalid_i,
    input  logic [DATA_W-1:0]       bus_data_i
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic [2:0] {
        F_IDLE, F_WB, F_REQ, F_SHR, F_DATA, F_DONE
    } fsm_t;

    fsm_t              fsm_q, fsm_d;
    logic              op_we;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic              shr_q;
    logic              accept;
    logic              hit;
    logic [TAG_W-1:0]  cpu_tag;

    assign cpu_tag     = cpu_addr_i[ADDR_W-1 -: TAG_W];
    assign accept      = (fsm_q == F_IDLE) && cpu_req_i && !snoop_busy_i;
    assign idx_o       = (fsm_q == F_IDLE) ? cpu_addr_i[IDX_W-1:0] : op_addr[IDX_W-1:0];
    assign hit         = (st_i != ST_I) && (tag_i == cpu_tag);
    assign bus_req_o   = (fsm_q == F_WB) || (fsm_q == F_REQ);
    assign cpu_ready_o = (fsm_q == F_DONE);

    // Next state, line-store writes and address-phase drive.
    always_comb begin
        fsm_d      = fsm_q;
        we_o       = 1'b0;
        st_new_o   = ST_I;
        tag_new_o  = op_addr[ADDR_W-1 -: TAG_W];
        data_new_o = op_wdata;
        bus_av_o   = 1'b0;
        bus_cmd_o  = CMD_NONE;
        bus_addr_o = op_addr;
        bus_data_o = data_i;
        case (fsm_q)
            F_IDLE: if (accept) begin
                if (hit && !cpu_we_i) begin
                    fsm_d = F_DONE;
                end else if (hit && (st_i == ST_E || st_i == ST_M)) begin
                    we_o       = 1'b1;
                    st_new_o   = ST_M;
                    tag_new_o  = cpu_tag;
                    data_new_o = cpu_wdata_i;
                    fsm_d      = F_DONE;
                end else if (!hit && st_i == ST_M) begin
                    fsm_d = F_WB;
                end else begin
                    fsm_d = F_REQ;
                end
            end
            F_WB: if (bus_gnt_i) begin
                if (st_i == ST_M) begin
                    bus_av_o   = 1'b1;
                    bus_cmd_o  = CMD_WB;
                    bus_addr_o = {tag_i, op_addr[IDX_W-1:0]};
                    we_o       = 1'b1;
                    st_new_o   = ST_I;
                    tag_new_o  = tag_i;
                    data_new_o = data_i;
                end
                fsm_d = F_REQ;
            end
            F_REQ: if (bus_gnt_i) begin
                bus_av_o  = 1'b1;
                bus_cmd_o = op_we ? CMD_RDX : CMD_RD;
                fsm_d     = F_SHR;
            end
            F_SHR: fsm_d = F_DATA;
            F_DATA: if (bus_dvalid_i) begin
                we_o       = 1'b1;
                st_new_o   = op_we ? ST_M : (shr_q ? ST_S : ST_E);
                data_new_o = op_we ? op_wdata : bus_data_i;
                fsm_d      = F_DONE;
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    // State register, operation latch, vote sample and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= F_IDLE;
            op_we       <= 1'b0;
            op_addr     <= '0;
            op_wdata    <= '0;
            shr_q       <= 1'b0;
            cpu_rdata_o <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (accept) begin
                op_we    <= cpu_we_i;
                op_addr  <= cpu_addr_i;
                op_wdata <= cpu_wdata_i;
                if (hit && !cpu_we_i)
                    cpu_rdata_o <= data_i;
            end
            if (fsm_q == F_SHR)
                shr_q <= bus_shared_i;
            if (fsm_q == F_DATA && bus_dvalid_i)
                cpu_rdata_o <= op_we ? op_wdata : bus_data_i;
        end
    end
endmodule

// File: rtl/mesi_cache.sv
// Top of the snooping write-back cache controller: joins the line store, the
// request side and the snoop side. Memory inhibit follows every flush of dirty
// data. Assumes an atomic bus with one address phase at a time.
module mesi_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ready_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_av_o,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_shared_i,
    input  logic              bus_dvalid_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_data_o,
    output logic              mem_inhibit_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, b_idx;
    line_st_t          a_st, b_st, a_st_new, b_st_new;
    logic [TAG_W-1:0]  a_tag, b_tag, a_tag_new;
    logic [DATA_W-1:0] a_data, b_data, a_data_new;
    logic              a_we, b_we, snp_busy;

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx_i(a_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
        .a_we_i(a_we), .a_st_i(a_st_new), .a_tag_i(a_tag_new), .a_data_i(a_data_new),
        .b_idx_i(b_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
        .b_we_i(b_we), .b_st_i(b_st_new)
    );

    mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
        .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
        .snoop_busy_i(snp_busy),
        .idx_o(a_idx), .st_i(a_st), .tag_i(a_tag), .data_i(a_data),
        .we_o(a_we), .st_new_o(a_st_new), .tag_new_o(a_tag_new), .data_new_o(a_data_new),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_av_o(bus_av_o),
        .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .bus_shared_i(bus_shared_i), .bus_dvalid_i(bus_dvalid_i), .bus_data_i(bus_data_i)
    );

    mesi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid_i(snp_valid_i), .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i),
        .idx_o(b_idx), .st_i(b_st), .tag_i(b_tag), .data_i(b_data),
        .st_we_o(b_we), .st_new_o(b_st_new),
        .vote_o(shared_o), .flush_o(flush_o), .flush_data_o(flush_data_o),
        .busy_o(snp_busy)
    );

    assign mem_inhibit_o = flush_o;
endmodule

// File: rtl/mesi_cache_chk.sv
// Protocol checker for the cache controller, bound to every instance of the top.
module mesi_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready_o,
    input logic       bus_req_o,
    input logic       bus_gnt_i,
    input logic       bus_av_o,
    input logic [1:0] bus_cmd_o,
    input logic       snp_valid_i,
    input logic [1:0] snp_cmd_i,
    input logic       shared_o,
    input logic       flush_o
);
    // R6
    vote_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared_o |-> ($past(snp_valid_i) && $past(snp_cmd_i) == 2'd1));

    // R7
    flush_after_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ($past(snp_valid_i) && ($past(snp_cmd_i) == 2'd1 || $past(snp_cmd_i) == 2'd2)));

    // R12
    phase_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_av_o |-> bus_gnt_i);

    // R4
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |=> !cpu_ready_o);

    // R10
    fill_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_av_o && bus_cmd_o == 2'd3) |=> bus_req_o);
endmodule

bind mesi_cache mesi_cache_chk u_chk (.*);

// File: tb/mesi_cache_tb.sv
`timescale 1ns/1ps
module mesi_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready_o;
    logic [31:0] cpu_rdata_o;
    logic        bus_req_o, bus_av_o;
    logic        bus_gnt = 1'b0, bus_shared = 1'b0, bus_dvalid = 1'b0;
    logic [1:0]  bus_cmd_o;
    logic [11:0] bus_addr_o;
    logic [31:0] bus_data_o, bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [11:0] snp_addr = '0;
    logic        shared_o, flush_o, mem_inhibit_o;
    logic [31:0] flush_data_o;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    mesi_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
        .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_av_o(bus_av_o),
        .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .bus_shared_i(bus_shared), .bus_dvalid_i(bus_dvalid), .bus_data_i(bus_rdata),
        .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .shared_o(shared_o), .flush_o(flush_o), .flush_data_o(flush_data_o),
        .mem_inhibit_o(mem_inhibit_o)
    );

    function automatic logic [31:0] fill_of(input logic [11:0] a);
        return 32'hC0DE_0000 | {20'h0, a};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One processor access with a bus model: grant, shared vote, fill.
    // shmode: 0 no vote, 1 vote in the sampling cycle, 2 vote one cycle late.
    task automatic do_op(input logic we, input logic [11:0] a, input logic [31:0] wd, input int shmode,
                         output int ntx, output logic [1:0] c0, output logic [11:0] a0,
                         output logic [31:0] d0, output logic [1:0] c1, output logic [11:0] a1,
                         output logic [31:0] rd);
        int ph = 0;
        bit done = 0;
        logic [11:0] faddr = '0;
        ntx = 0; c0 = '0; a0 = '0; d0 = '0; c1 = '0; a1 = '0; rd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int k = 0; k < 60 && !done; k++) begin
            @(negedge clk);
            if (bus_gnt) bus_gnt = 1'b0;
            case (ph)
                1: begin bus_shared = (shmode == 1); ph = 2; end
                2: begin bus_shared = (shmode == 2); bus_dvalid = 1'b1; bus_rdata = fill_of(faddr); ph = 3; end
                3: begin bus_shared = 1'b0; bus_dvalid = 1'b0; ph = 0; end
                default: ;
            endcase
            if (ph == 0 && cpu_ready_o) begin
                rd = cpu_rdata_o; done = 1; cpu_req = 1'b0;
            end else if (ph == 0 && bus_req_o) begin
                bus_gnt = 1'b1;
                #1;
                if (bus_av_o) begin
                    if (ntx == 0) begin c0 = bus_cmd_o; a0 = bus_addr_o; d0 = bus_data_o; end
                    else begin c1 = bus_cmd_o; a1 = bus_addr_o; end
                    ntx++;
                    if (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2) begin ph = 1; faddr = bus_addr_o; end
                end
            end
        end
        if (!done) begin
            total++; bad++; cpu_req = 1'b0; bus_gnt = 1'b0;
            $display("FAIL R4 access did not complete act=0 exp=1");
        end
    endtask

    // Another controller's address phase; observe the response one cycle later.
    task automatic do_snoop(input logic [1:0] c, input logic [11:0] a,
                            output logic v, output logic f, output logic inh, output logic [31:0] fd);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = '0;
        v = shared_o; f = flush_o; inh = mem_inhibit_o; fd = flush_data_o;
        @(negedge clk);
    endtask

    int n; logic [1:0] c0, c1; logic [11:0] a0, a1; logic [31:0] d0, rd;
    logic v, f, inh; logic [31:0] fd;

    task automatic t_reset();
        chk("R1", "bus_req", 32'(bus_req_o), 0);
        chk("R1", "ready", 32'(cpu_ready_o), 0);
        chk("R1", "vote", 32'(shared_o), 0);
        chk("R1", "flush", 32'(flush_o), 0);
        do_op(0, 12'h010, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R1", "miss count", 32'(n), 1);
        chk("R2", "read cmd", 32'(c0), 1);
        chk("R2", "fill data", rd, fill_of(12'h010));
    endtask

    task automatic t_exclusive();
        do_op(0, 12'h010, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R4", "hit no bus", 32'(n), 0);
        chk("R4", "hit data", rd, fill_of(12'h010));
        do_op(1, 12'h010, 32'h1111_2222, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R2", "silent upgrade", 32'(n), 0);
        do_snoop(2'd1, 12'h010, v, f, inh, fd);
        chk("R6", "vote on M", 32'(v), 1);
        chk("R7", "flush", 32'(f), 1);
        chk("R7", "inhibit", 32'(inh), 1);
        chk("R7", "flush data", fd, 32'h1111_2222);
        do_op(1, 12'h010, 32'h3333_4444, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R7", "now shared rdx", 32'(c0), 2);
    endtask

    task automatic t_shared();
        do_op(0, 12'h021, 0, 1, n, c0, a0, d0, c1, a1, rd);
        chk("R3", "read cmd", 32'(c0), 1);
        do_op(1, 12'h021, 32'h5555_6666, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R3", "write in S count", 32'(n), 1);
        chk("R3", "write in S cmd", 32'(c0), 2);
        chk("R3", "write in S addr", 32'(a0), 32'h021);
    endtask

    task automatic t_rdx_snoops();
        do_snoop(2'd2, 12'h021, v, f, inh, fd);
        chk("R9", "rdx on M flush", 32'(f), 1);
        chk("R9", "rdx flush data", fd, 32'h5555_6666);
        chk("R9", "rdx no vote", 32'(v), 0);
        do_op(0, 12'h021, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R9", "M invalidated", 32'(c0), 1);
        do_op(0, 12'h003, 0, 1, n, c0, a0, d0, c1, a1, rd);
        do_snoop(2'd2, 12'h003, v, f, inh, fd);
        chk("R9", "rdx on S no flush", 32'(f), 0);
        do_op(0, 12'h003, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R9", "S invalidated", 32'(n), 1);
    endtask

    task automatic t_e_snoop();
        do_op(0, 12'h032, 0, 0, n, c0, a0, d0, c1, a1, rd);
        do_snoop(2'd1, 12'h032, v, f, inh, fd);
        chk("R6", "vote on E", 32'(v), 1);
        chk("R8", "no flush on E", 32'(f), 0);
        do_op(1, 12'h032, 32'h7777_8888, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R8", "E demoted to S", 32'(c0), 2);
        do_snoop(2'd1, 12'h7F3, v, f, inh, fd);
        chk("R6", "tag miss no vote", 32'(v), 0);
    endtask

    task automatic t_evict();
        do_op(1, 12'h104, 32'h9999_AAAA, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R10", "wb count", 32'(n), 2);
        chk("R10", "wb cmd", 32'(c0), 3);
        chk("R10", "wb addr", 32'(a0), 32'h010);
        chk("R10", "wb data", d0, 32'h3333_4444);
        chk("R5", "write miss cmd", 32'(c1), 2);
        chk("R5", "write miss addr", 32'(a1), 32'h104);
        do_op(0, 12'h104, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R5", "read back", rd, 32'h9999_AAAA);
        do_op(0, 12'h0A1, 0, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R10", "clean evict silent", 32'(n), 1);
    endtask

    task automatic t_late_vote();
        do_op(0, 12'h0C2, 0, 2, n, c0, a0, d0, c1, a1, rd);
        chk("R10", "dirty victim wb addr", 32'(a0), 32'h032);
        chk("R11", "fill data", rd, fill_of(12'h0C2));
        do_op(1, 12'h0C2, 32'hBBBB_CCCC, 0, n, c0, a0, d0, c1, a1, rd);
        chk("R11", "late vote ignored", 32'(n), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exclusive();
        t_shared();
        t_rdx_snoops();
        t_e_snoop();
        t_evict();
        t_late_vote();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule